// File: doc/BRIEF.md
# Hidden Command Register Unlock Decoder

This block decodes host accesses to the four I/O ports of a palette DAC: the pixel mask port, the read-address port, the write-address port and the data port. The command register has no address of its own. A run of reads on the mask port opens it. Once it is open, every later read or write of the mask port reaches the command register rather than the pixel mask. Any access to one of the other three ports closes it again, and the mask port goes back to the pixel mask.

The command byte is decoded into mode outputs. One of two layouts is chosen by parameter. The flag layout uses one bit each for high-color, 16-bit and two-clock latching. The mode-field layout carries a three-bit mode code and a DAC width bit. The palette RAM is not part of this block. The address and data ports are decoded only so that they close the command register.

Top module: `dac_host_regs`

## Requirements
- R1: After reset the pixel mask is FFh, the command register is 00h and the mask port is locked (it shows the pixel mask).
- R2: Port select encoding: `bus_addr` 0 is the mask port, 1 the read-address port, 2 the write-address port, 3 the data port. A read of a locked mask port returns the pixel mask. Reads of ports 1 to 3 return 00h.
- R3: After UNLOCK_READS (default 4) mask-port reads with no other access in between, the mask port unlocks. The last read of the run still returns the pixel mask. After only three reads it stays locked.
- R4: Any read or write of port 1, 2 or 3 locks the mask port and clears the read count.
- R5: A mask-port write while locked stores the pixel mask, clears the read count and leaves the command register unchanged.
- R6: While unlocked, mask-port writes load the command register and leave the pixel mask unchanged. Mask-port reads return the command register and do not change the unlocked state.
- R7: Flag layout (MODE_FIELD=0): `hicolor_en` is bit 7, `sel16` is bit 7 AND bit 6, `two_clk_latch` is bit 5. `sel24` and `dac_8bit` are 0.
- R8: Mode-field layout (MODE_FIELD=1), with mode = bits 7:5. Mode 5, 6 or 7 sets `hicolor_en`. Mode 6 sets `sel16`. Mode 7 sets `sel24`. Mode 0 with bit 1 set sets `dac_8bit`. `two_clk_latch` is 0.
- R9: A cycle with both `bus_rd` and `bus_wr` high is treated as a write only.
- R10: Idle cycles (no strobe) do not change the read count or the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select (R2 encoding) |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from current state |
| pix_mask | output | DATA_W | Pixel mask register |
| hicolor_en | output | 1 | High-color mode enable |
| sel16 | output | 1 | 16-bit pixel mode |
| sel24 | output | 1 | 24-bit pixel mode (mode-field layout only) |
| two_clk_latch | output | 1 | Pixel bytes latched on two clocks (flag layout only) |
| dac_8bit | output | 1 | 8-bit DAC width (mode-field layout only) |

## Verification
The bench builds two instances side by side on one bus, both with DATA_W=8 and UNLOCK_READS=4. One uses the flag layout and one the mode-field layout. Every command value written is therefore checked against both decodings in the same cycle. Keeping the unlock count at four lets the directed cases cover three reads versus four reads and relocking. Random mixes of mask reads, writes, other-port accesses and idle cycles then exercise counter saturation and clearing.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;
   typedef enum logic [1:0] {
      PORT_MASK  = 2'd0,
      PORT_RADDR = 2'd1,
      PORT_WADDR = 2'd2,
      PORT_DATA  = 2'd3
   } port_e;

   typedef struct packed {
      logic hicolor;
      logic sel16;
      logic sel24;
      logic two_clk;
      logic wide_dac;
   } cmd_fields_t;
endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq #(
   parameter int UNLOCK_READS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mask_rd,
   input  logic mask_wr,
   input  logic other_acc,
   output logic unlocked
);
   localparam int CW = $clog2(UNLOCK_READS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(UNLOCK_READS);

   logic [CW-1:0] cnt_q;

   assign unlocked = (cnt_q == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (other_acc) begin
         cnt_q <= '0;
      end else if (mask_wr && !unlocked) begin
         cnt_q <= '0;
      end else if (mask_rd && !unlocked) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_host_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit MODE_FIELD = 1'b0
) (
   input  logic [DATA_W-1:0] cmd,
   output cmd_fields_t       fields
);
   generate
      if (MODE_FIELD) begin : g_mode_field
         logic [2:0] mode;
         assign mode             = cmd[7:5];
         assign fields.hicolor   = (mode >= 3'd5);
         assign fields.sel16     = (mode == 3'd6);
         assign fields.sel24     = (mode == 3'd7);
         assign fields.two_clk   = 1'b0;
         assign fields.wide_dac  = (mode == 3'd0) && cmd[1];
      end else begin : g_flags
         assign fields.hicolor   = cmd[7];
         assign fields.sel16     = cmd[7] & cmd[6];
         assign fields.sel24     = 1'b0;
         assign fields.two_clk   = cmd[5];
         assign fields.wide_dac  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dac_host_regs.sv
module dac_host_regs
   import dac_host_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int UNLOCK_READS = 4,
   parameter bit MODE_FIELD   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] pix_mask,
   output logic              hicolor_en,
   output logic              sel16,
   output logic              sel24,
   output logic              two_clk_latch,
   output logic              dac_8bit
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("dac_host_regs: DATA_W must be at least 8");
      end
      if (UNLOCK_READS < 1) begin : g_bad_count
         $error("dac_host_regs: UNLOCK_READS must be at least 1");
      end
   endgenerate

   localparam logic [DATA_W-1:0] MASK_RST = '1;
   localparam logic [DATA_W-1:0] CMD_RST  = '0;

   port_e       port;
   logic        mask_sel;
   logic        mask_rd;
   logic        mask_wr;
   logic        other_acc;
   logic        unlocked;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] cmd_q;
   cmd_fields_t fields;

   assign port      = port_e'(bus_addr);
   assign mask_sel  = (port == PORT_MASK);
   assign mask_wr   = mask_sel && bus_wr;
   assign mask_rd   = mask_sel && bus_rd && !bus_wr;
   assign other_acc = !mask_sel && (bus_rd || bus_wr);

   dac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_rd  (mask_rd),
      .mask_wr  (mask_wr),
      .other_acc(other_acc),
      .unlocked (unlocked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= MASK_RST;
         cmd_q  <= CMD_RST;
      end else if (mask_wr) begin
         if (unlocked) cmd_q  <= bus_wdata;
         else          mask_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (mask_sel) bus_rdata = unlocked ? cmd_q : mask_q;
   end

   dac_cmd_decode #(.DATA_W(DATA_W), .MODE_FIELD(MODE_FIELD)) u_dec (
      .cmd   (cmd_q),
      .fields(fields)
   );

   assign pix_mask      = mask_q;
   assign hicolor_en    = fields.hicolor;
   assign sel16         = fields.sel16;
   assign sel24         = fields.sel24;
   assign two_clk_latch = fields.two_clk;
   assign dac_8bit      = fields.wide_dac;
endmodule

// File: rtl/dac_host_regs_chk.sv
module dac_host_regs_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] pix_mask,
   input logic              hicolor_en,
   input logic              sel16,
   input logic              unlocked
);
   assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && bus_addr != 2'd0) |=> !unlocked);

   assert_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && bus_rd && !bus_wr && bus_addr == 2'd0) |=> unlocked);

   assert_cmd_write_keeps_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && bus_wr && bus_addr == 2'd0) |=> $stable(pix_mask));

   assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && bus_wr && bus_addr == 2'd0) |=> (pix_mask == $past(bus_wdata)) && !unlocked);

   assert_sel16_needs_hicolor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel16 |-> hicolor_en);

   assert_idle_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd && !bus_wr) |=> $stable(unlocked) && $stable(pix_mask));
endmodule

bind dac_host_regs dac_host_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .pix_mask  (pix_mask),
   .hicolor_en(hicolor_en),
   .sel16     (sel16),
   .unlocked  (unlocked)
);

// File: tb/tb_dac_host_regs.sv
module tb_dac_host_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] rd0, rd1, mk0, mk1;
   logic       hc0, s160, s240, tc0, w80;
   logic       hc1, s161, s241, tc1, w81;

   int n_checks = 0, n_fail = 0;
   int m_cnt = 0;
   logic [7:0] m_mask = 8'hFF, m_cmd = 8'h00;

   always #4 clk = ~clk;

   dac_host_regs #(.DATA_W(8), .UNLOCK_READS(4), .MODE_FIELD(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(rd0), .pix_mask(mk0), .hicolor_en(hc0),
      .sel16(s160), .sel24(s240), .two_clk_latch(tc0), .dac_8bit(w80));

   dac_host_regs #(.DATA_W(8), .UNLOCK_READS(4), .MODE_FIELD(1'b1)) dut_mf (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(rd1), .pix_mask(mk1), .hicolor_en(hc1),
      .sel16(s161), .sel24(s241), .two_clk_latch(tc1), .dac_8bit(w81));

   function automatic logic [4:0] exp_flags(input logic [7:0] c);
      return {c[7], c[7] & c[6], 1'b0, c[5], 1'b0};
   endfunction

   function automatic logic [4:0] exp_mode(input logic [7:0] c);
      logic [2:0] m;
      m = c[7:5];
      return {m >= 3'd5, m == 3'd6, m == 3'd7, 1'b0, (m == 3'd0) && c[1]};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_outs();
      chk("R5 mask flag inst", mk0, m_mask);
      chk("R5 mask mode inst", mk1, m_mask);
      chk("R7 flag decode", {3'b0, hc0, s160, s240, tc0, w80}, {3'b0, exp_flags(m_cmd)});
      chk("R8 mode decode", {3'b0, hc1, s161, s241, tc1, w81}, {3'b0, exp_mode(m_cmd)});
   endtask

   task automatic acc(input logic [1:0] a, input logic r, input logic w,
                      input logic [7:0] d, input string tag);
      logic [7:0] exp;
      @(negedge clk);
      bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
      #1;
      if (r && !w) begin
         exp = (a == 2'd0) ? ((m_cnt == 4) ? m_cmd : m_mask) : 8'h00;
         chk(tag, rd0, exp);
         chk(tag, rd1, exp);
      end
      @(posedge clk);
      if ((r || w) && a != 2'd0) m_cnt = 0;
      else if (a == 2'd0 && w) begin
         if (m_cnt == 4) m_cmd = d;
         else begin m_mask = d; m_cnt = 0; end
      end else if (a == 2'd0 && r && m_cnt < 4) m_cnt++;
      #1;
      bus_rd = 1'b0; bus_wr = 1'b0;
      check_outs();
   endtask

   task automatic unlock();
      for (int i = 0; i < 4; i++) acc(2'd0, 1'b1, 1'b0, 8'h00, "R3 unlock run");
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      int unsigned seed;
      int unsigned r;
      seed = 32'h5EED_0042;
      r = $urandom(seed);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 mask reset", mk0, 8'hFF);
      chk("R1 cmd decode reset", {3'b0, hc0, s160, s240, tc0, w80}, 8'h00);
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R1 locked after reset");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R2 mask read");
      acc(2'd1, 1'b1, 1'b0, 8'h00, "R2 other port reads zero");
      // R3 three reads stay locked
      for (int i = 0; i < 3; i++) acc(2'd0, 1'b1, 1'b0, 8'h00, "R3 three reads");
      acc(2'd2, 1'b0, 1'b1, 8'h11, "R4 waddr write");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R3 still mask after three");
      acc(2'd3, 1'b1, 1'b0, 8'h00, "R4 data read");
      unlock();
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R3 cmd visible");
      acc(2'd0, 1'b0, 1'b1, 8'hE0, "R6 cmd write");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R6 cmd readback");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R6 still unlocked");
      acc(2'd1, 1'b0, 1'b1, 8'h05, "R4 raddr relock");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R4 mask visible again");
      // R5 mask write mid-run clears count
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 pre");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 pre");
      acc(2'd0, 1'b0, 1'b1, 8'h3C, "R5 mask write");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 count cleared");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 count cleared");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 count cleared");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R5 still locked");
      // R9 rd and wr together: write only
      acc(2'd3, 1'b1, 1'b0, 8'h00, "R4 relock");
      acc(2'd0, 1'b1, 1'b1, 8'h5A, "R9 rd+wr write");
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R9 mask took write");
      // R10 idle cycles between reads
      acc(2'd3, 1'b0, 1'b1, 8'h00, "R4 relock");
      for (int i = 0; i < 4; i++) begin
         acc(2'd0, 1'b1, 1'b0, 8'h00, "R10 read");
         acc(2'd2, 1'b0, 1'b0, 8'h00, "R10 idle");
      end
      acc(2'd0, 1'b1, 1'b0, 8'h00, "R10 unlocked through idles");
      // R7/R8 decode values
      acc(2'd0, 1'b0, 1'b1, 8'hA0, "R8 mode 5");
      acc(2'd0, 1'b0, 1'b1, 8'hC0, "R8 mode 6");
      acc(2'd0, 1'b0, 1'b1, 8'hE0, "R8 mode 7");
      acc(2'd0, 1'b0, 1'b1, 8'h02, "R8 wide dac");
      acc(2'd0, 1'b0, 1'b1, 8'h60, "R7 bit6 without bit7");
      acc(2'd0, 1'b0, 1'b1, 8'h20, "R7 two clock");
      // random mix
      for (int i = 0; i < 600; i++) begin
         r = $urandom % 10;
         if (r < 5)       acc(2'd0, 1'b1, 1'b0, 8'h00, "R3 rand read");
         else if (r < 7)  acc(2'd0, 1'b0, 1'b1, 8'($urandom), "R6 rand write");
         else if (r == 7) acc(2'($urandom % 3 + 1), 1'($urandom), 1'b1, 8'($urandom), "R4 rand other");
         else if (r == 8) acc(2'($urandom), 1'b0, 1'b0, 8'h00, "R10 rand idle");
         else             acc(2'($urandom % 3 + 1), 1'b1, 1'b0, 8'h00, "R2 rand other read");
      end
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule